// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Release

This block is one clock prescaler shared by a group of five timer/counters. A free-running counter produces single-cycle clock-enable pulses at divide-by 1, 8, 64, 256 and 1024. Each timer has its own three-bit selector. The selector picks one of those enables, an already synchronized and edge-detected external tick, or nothing. The external tick never passes through the divider.

A three-bit control register sets the reset and synchronization behaviour. Bit 0 resets the shared divider. Bit 1 raises the reset line of a separate asynchronous-group prescaler. Bit 2 turns on synchronization mode. With bit 2 clear, a reset bit written to one lasts exactly one cycle and then clears itself. With bit 2 set, the written reset bits are kept, and a kept divider reset halts every prescaled timer so software can load them all. Writing bit 2 back to zero clears both reset bits, and every timer resumes counting on the same cycle.

A control FSM has four states:
- `ST_RUN`: no reset bit set and synchronization mode off.
- `ST_PULSE`: a one-shot reset is active for one cycle.
- `ST_ARMED`: synchronization mode on, no reset bit kept.
- `ST_HELD`: synchronization mode on, at least one reset bit kept.

Its transitions are:
- One-shot writes go from `ST_RUN` or `ST_PULSE` to `ST_PULSE`.
- `ST_PULSE` falls back to `ST_RUN` when there is no write.
- Writes with bit 2 set go to `ST_ARMED` or `ST_HELD`, depending on whether any reset bit is written.
- A release write (bit 2 clear) from `ST_ARMED` or `ST_HELD` goes to `ST_RUN`.

Top module: `shared_prescaler`

## Requirements
- R1: After reset the read-back value is 0, synchronization mode is off and the divider counter is zero.
- R2: A timer with selector 1 gets a tick on every cycle in which the divider reset (bit 0) is not asserted.
- R3: Selectors 2, 3, 4 and 5 give single-cycle ticks at divide-by 8, 64, 256 and 1024. Each tick comes when the low 3, 6, 8 or 10 bits of the divider counter are all ones.
- R4: A write with bit 2 clear and bit 0 set shows bit 0 as one for exactly one cycle and forces the counter to zero. Prescaled ticks are suppressed in that cycle. The first divide-by-N tick then comes on the Nth cycle after the reset cycle.
- R5: A write with bit 2 clear and bit 1 set drives `async_rst_o` high for exactly one cycle and leaves the shared divider running.
- R6: While bit 2 is set, the written reset bits are kept unchanged until the next write.
- R7: While bit 0 is kept, all timers with selectors 1 to 5 get no ticks and the counter stays at zero.
- R8: A write with bit 2 clear made while synchronization mode is on clears bits 0, 1 and 2, whatever bits 1:0 of the written data are. All prescaled timers restart on the next cycle, and a divide-by-1 timer ticks in that cycle.
- R9: Selector 6 routes the timer's `ext_tick` bit straight to its tick output, whether or not the divider is reset.
- R10: Selectors 0 and 7 give no ticks.
- R11: `rd_data` always shows the current state, including self-clearing: bit 0 is the divider reset, bit 1 the asynchronous-group reset, bit 2 the synchronization mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | Write value: bit0 divider reset, bit1 async-group reset, bit2 sync mode |
| rd_data | output | 3 | Current control state, same layout as `wr_data` |
| clk_sel | input | 3*N_TIMERS | Per-timer selector, timer i in bits [3i+2:3i] |
| ext_tick | input | N_TIMERS | Per-timer synchronized external edge pulse |
| timer_tick | output | N_TIMERS | Per-timer count enable |
| async_rst_o | output | 1 | Reset request to the asynchronous-group prescaler |

## Verification
The assertions assume that `ext_tick` is already a clean, clock-synchronous pulse. They also assume that `clk_sel` changes only between clock edges. The bench holds to both: it drives every input at the falling edge, and it steps `ext_tick` from a linear-feedback register. Synchronization mode is only ever left by an explicit write with bit 2 clear, and release writes are issued with stray reset bits in their data to exercise R8.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int REG_W    = 3;
    localparam int SRST_BIT = 0;
    localparam int ARST_BIT = 1;
    localparam int HOLD_BIT = 2;
    localparam int SEL_W    = 3;
    localparam int N_TAPS   = 4;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_PULSE,
        ST_ARMED,
        ST_HELD
    } ctrl_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF     = 3'd0,
        SEL_DIV1    = 3'd1,
        SEL_DIV8    = 3'd2,
        SEL_DIV64   = 3'd3,
        SEL_DIV256  = 3'd4,
        SEL_DIV1024 = 3'd5,
        SEL_EXT     = 3'd6,
        SEL_OFF_ALT = 3'd7
    } clk_sel_e;

    // log2 of the divide ratio for each prescaled tap
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
    import presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             sync_rst,
    output logic             async_rst
);

    ctrl_state_e state_q, state_d;
    logic [1:0]  bits_q, bits_d;
    logic        any_rst_wr;

    assign any_rst_wr = wr_data[SRST_BIT] | wr_data[ARST_BIT];

    // next-state
    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        unique case (state_q)
            ST_RUN, ST_PULSE: begin
                if (wr_en) begin
                    bits_d = {wr_data[ARST_BIT], wr_data[SRST_BIT]};
                    if (wr_data[HOLD_BIT])
                        state_d = any_rst_wr ? ST_HELD : ST_ARMED;
                    else
                        state_d = any_rst_wr ? ST_PULSE : ST_RUN;
                end else begin
                    bits_d  = 2'b00;
                    state_d = ST_RUN;
                end
            end
            ST_ARMED, ST_HELD: begin
                if (wr_en) begin
                    if (wr_data[HOLD_BIT]) begin
                        bits_d  = {wr_data[ARST_BIT], wr_data[SRST_BIT]};
                        state_d = any_rst_wr ? ST_HELD : ST_ARMED;
                    end else begin
                        bits_d  = 2'b00;
                        state_d = ST_RUN;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            bits_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
        end
    end

    // outputs
    always_comb begin
        logic hold;
        hold      = (state_q == ST_ARMED) || (state_q == ST_HELD);
        sync_rst  = bits_q[0];
        async_rst = bits_q[1];
        rd_data   = '0;
        rd_data[HOLD_BIT] = hold;
        rd_data[ARST_BIT] = bits_q[1];
        rd_data[SRST_BIT] = bits_q[0];
    end

endmodule

// File: rtl/presc_divider.sv
module presc_divider
    import presc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [N_TAPS:0] tap_en
);

    localparam int CNT_W = tap_shift(N_TAPS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tap_en[0] = !clr;

    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        localparam int SH = tap_shift(k);
        assign tap_en[k+1] = !clr && (&cnt_q[SH-1:0]);
    end

endmodule

// File: rtl/presc_tap_sel.sv
module presc_tap_sel
    import presc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [N_TAPS:0]  tap_en,
    input  logic             ext_tick,
    output logic             tick
);

    always_comb begin
        unique case (clk_sel_e'(sel))
            SEL_DIV1:    tick = tap_en[0];
            SEL_DIV8:    tick = tap_en[1];
            SEL_DIV64:   tick = tap_en[2];
            SEL_DIV256:  tick = tap_en[3];
            SEL_DIV1024: tick = tap_en[4];
            SEL_EXT:     tick = ext_tick;
            SEL_OFF, SEL_OFF_ALT: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler
    import presc_pkg::*;
#(
    parameter int N_TIMERS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    input  logic [SEL_W*N_TIMERS-1:0] clk_sel,
    input  logic [N_TIMERS-1:0]       ext_tick,
    output logic [N_TIMERS-1:0]       timer_tick,
    output logic                      async_rst_o
);

    logic            sync_rst;
    logic [N_TAPS:0] tap_en;

    presc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .sync_rst  (sync_rst),
        .async_rst (async_rst_o)
    );

    presc_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sync_rst),
        .tap_en (tap_en)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
        presc_tap_sel u_sel (
            .sel      (clk_sel[i*SEL_W +: SEL_W]),
            .tap_en   (tap_en),
            .ext_tick (ext_tick[i]),
            .tick     (timer_tick[i])
        );
    end

endmodule

// File: rtl/presc_checker.sv
module presc_checker
    import presc_pkg::*;
#(
    parameter int N_TIMERS = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [REG_W-1:0]          wr_data,
    input logic [REG_W-1:0]          rd_data,
    input logic [SEL_W*N_TIMERS-1:0] clk_sel,
    input logic [N_TIMERS-1:0]       ext_tick,
    input logic [N_TIMERS-1:0]       timer_tick,
    input logic                      async_rst_o,
    input logic [N_TAPS:0]           tap_en
);

    logic [N_TIMERS-1:0] presc_mask;
    always_comb begin
        for (int i = 0; i < N_TIMERS; i++) begin
            presc_mask[i] = (clk_sel[i*SEL_W +: SEL_W] >= 3'd1) &&
                            (clk_sel[i*SEL_W +: SEL_W] <= 3'd5);
        end
    end

    a_r4_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SRST_BIT] && !rd_data[HOLD_BIT] && !wr_en) |=> !rd_data[SRST_BIT]);

    a_r5_async_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (async_rst_o && !rd_data[HOLD_BIT] && !wr_en) |=> !async_rst_o);

    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[HOLD_BIT] && !wr_en) |=> $stable(rd_data));

    a_r7_halted: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SRST_BIT] |-> ((timer_tick & presc_mask) == '0));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[HOLD_BIT] && wr_en && !wr_data[HOLD_BIT]) |=> (rd_data == '0));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[1] |=> !tap_en[1]);

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
        a_r9_ext_held: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[SRST_BIT] && clk_sel[i*SEL_W +: SEL_W] == 3'd6)
            |-> (timer_tick[i] == ext_tick[i]));
        a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel[i*SEL_W +: SEL_W] == 3'd0 || clk_sel[i*SEL_W +: SEL_W] == 3'd7)
            |-> !timer_tick[i]);
    end

endmodule

bind shared_prescaler presc_checker #(.N_TIMERS(N_TIMERS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .clk_sel     (clk_sel),
    .ext_tick    (ext_tick),
    .timer_tick  (timer_tick),
    .async_rst_o (async_rst_o),
    .tap_en      (tap_en)
);

// File: tb/shared_prescaler_test.sv
`timescale 1ns/1ps
module shared_prescaler_test;

    localparam int NT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_data = '0;
    logic [2:0]    rd_data;
    logic [3*NT-1:0] clk_sel = '0;
    logic [NT-1:0] ext_tick = '0;
    logic [NT-1:0] timer_tick;
    logic          async_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic       m_hold = 1'b0;
    logic [1:0] m_bits = 2'b00;
    int         m_cnt  = 0;
    logic [7:0] lfsr   = 8'h5a;

    always #2 clk = ~clk;

    shared_prescaler #(.N_TIMERS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_sel(clk_sel), .ext_tick(ext_tick),
        .timer_tick(timer_tick), .async_rst_o(async_rst_o)
    );

    // reference model of the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 1'b0; m_bits = 2'b00; m_cnt = 0;
        end else begin
            m_cnt = m_bits[0] ? 0 : (m_cnt + 1) % 1024;
            if (wr_en) begin
                if (wr_data[2]) begin
                    m_hold = 1'b1; m_bits = wr_data[1:0];
                end else if (m_hold) begin
                    m_hold = 1'b0; m_bits = 2'b00;
                end else begin
                    m_bits = wr_data[1:0];
                end
            end else if (!m_hold) begin
                m_bits = 2'b00;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_tick(input int i);
        int s = int'(clk_sel[i*3 +: 3]);
        bit run = !m_bits[0];
        case (s)
            1: return run;
            2: return run && (m_cnt % 8 == 7);
            3: return run && (m_cnt % 64 == 63);
            4: return run && (m_cnt % 256 == 255);
            5: return run && (m_cnt % 1024 == 1023);
            6: return ext_tick[i];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_for(input int i);
        int s = int'(clk_sel[i*3 +: 3]);
        if (s >= 1 && s <= 5 && m_bits[0]) return "R7";
        case (s)
            1: return "R2";
            2, 3, 4, 5: return "R3";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare_all();
        check(rd_data == {m_hold, m_bits}, "R11", rd_data, {m_hold, m_bits});
        check(async_rst_o == m_bits[1], "R5", async_rst_o, m_bits[1]);
        for (int i = 0; i < NT; i++)
            check(timer_tick[i] == exp_tick(i), tag_for(i), timer_tick[i], exp_tick(i));
    endtask

    task automatic step(input bit w, input logic [2:0] d);
        @(negedge clk);
        wr_en = w; wr_data = d;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ext_tick = lfsr[NT-1:0];
        #1;
        compare_all();
    endtask

    task automatic set_sel(input int s0, input int s1, input int s2, input int s3, input int s4);
        clk_sel = {3'(s4), 3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_data == 3'b000, "R1", rd_data, 0);
        check(timer_tick == '0, "R1", timer_tick, 0);

        // sweep: every tap on its own timer
        set_sel(1, 2, 3, 4, 5);
        repeat (2100) step(0, 3'b000);

        // sweep: rotate all selectors over all timers
        for (int s = 0; s < 8; s++) begin
            set_sel(s % 8, (s + 1) % 8, (s + 2) % 8, (s + 3) % 8, (s + 4) % 8);
            repeat (1100) step(0, 3'b000);
        end

        set_sel(1, 2, 3, 4, 6);
        repeat (5) step(0, 3'b000);

        // R4 one-shot divider reset and first pulse distance
        step(1, 3'b001);
        step(0, 3'b000);
        check(rd_data == 3'b001, "R4", rd_data, 1);
        check(timer_tick[0] == 1'b0, "R4", timer_tick[0], 0);
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            step(0, 3'b000);
            if (k == 1) check(rd_data == 3'b000, "R4", rd_data, 0);
            if (timer_tick[1] && first == 0) first = k;
        end
        check(first == 8, "R4", first, 8);

        // R5 async one-shot
        step(1, 3'b010);
        step(0, 3'b000);
        check(async_rst_o == 1'b1, "R5", async_rst_o, 1);
        step(0, 3'b000);
        check(async_rst_o == 1'b0, "R5", async_rst_o, 0);
        repeat (30) step(0, 3'b000);

        // R6 hold mode kept, then R7 halt
        step(1, 3'b100);
        repeat (20) step(0, 3'b000);
        check(rd_data == 3'b100, "R6", rd_data, 4);
        step(1, 3'b101);
        repeat (40) step(0, 3'b000);
        check(rd_data == 3'b101, "R6", rd_data, 5);
        check((timer_tick & 5'b01111) == '0, "R7", timer_tick, 0);
        check(timer_tick[4] == ext_tick[4], "R9", timer_tick[4], ext_tick[4]);

        // R8 release with stray reset bits in the data
        step(1, 3'b011);
        step(0, 3'b000);
        check(rd_data == 3'b000, "R8", rd_data, 0);
        check(timer_tick[0] == 1'b1, "R8", timer_tick[0], 1);
        first = 0;
        for (int k = 2; k <= 70; k++) begin
            step(0, 3'b000);
            if (timer_tick[2] && first == 0) first = k;
        end
        check(first == 64, "R8", first, 64);

        // held both, cleared in hold mode, then released
        step(1, 3'b111);
        repeat (15) step(0, 3'b000);
        check(async_rst_o == 1'b1, "R6", async_rst_o, 1);
        step(1, 3'b100);
        repeat (25) step(0, 3'b000);
        step(1, 3'b000);
        repeat (1200) step(0, 3'b000);
        check(rd_data == 3'b000, "R11", rd_data, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule